// File: doc/BRIEF.md
# Single Wait-State Acknowledge Generator

This block inserts exactly one wait state into every RAM access of a processor memory bus. It halves a fast input clock to make the bus clock that the processor runs on. It drives an active-low transfer-acknowledge that the processor samples on each rising edge of that bus clock. The acknowledge is held inactive through the first sampling point of an access, so an access that would take two bus clocks takes three.

A DMA-acknowledge input forces the acknowledge inactive. An asynchronous master reset forces the bus clock high, the acknowledge inactive and the counter probe low. Its release is retimed to the fast clock. A spare clock input is passed through as a buffered copy and as an inverted copy.

The wait-state logic is updated from the fast clock. It acts only on those fast-clock edges where the bus clock goes from high to low. The acknowledge therefore changes on bus-clock falling edges only, half a bus period before the processor samples it.

Top module: `wait_ack_gen`

## Requirements
- R1: After reset release has taken effect, `bus_clk` inverts on every rising edge of `fast_clk`, so it runs at half the `fast_clk` frequency.
- R2: While `rst_n` is low, `bus_clk` is 1, `xfer_ack_n` is 1 and `cnt_probe` is 0. These values take effect at once, without waiting for a clock edge.
- R3: When `dma_ack` is 1 at a bus-clock falling edge, `xfer_ack_n` is 1 after that edge and the wait counter is cleared, whatever `ram_sel_n` is.
- R4: `xfer_ack_n` changes only at a bus-clock falling edge, that is, a `fast_clk` edge at which `bus_clk` goes from 1 to 0.
- R5: With `ram_sel_n` low (active) and `dma_ack` low, `xfer_ack_n` goes to 0 at the second bus-clock falling edge that sees `ram_sel_n` low. Take an access that starts at a bus-clock rising edge. The first rising edge after the start samples `xfer_ack_n` = 1, and the second samples 0, so the access spans three bus clocks.
- R6: When `ram_sel_n` is 1 at a bus-clock falling edge, `xfer_ack_n` is 1 after that edge and the wait counter is cleared.
- R7: `aux_clk_buf` equals `aux_clk_in`, and `aux_clk_inv` equals its complement.
- R8: `cnt_probe` shows the wait counter. It is 1 from the first bus-clock falling edge with an active, non-DMA select onward. It is 0 after any falling edge that sees `ram_sel_n` = 1 or `dma_ack` = 1.
- R9: After `rst_n` rises, `bus_clk` stays 1 for the next two `fast_clk` edges and falls at the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Fast input clock, twice the bus clock frequency |
| rst_n | input | 1 | Master reset, active low; asserts asynchronously, releases synchronously |
| aux_clk_in | input | 1 | Spare clock or signal to be buffered |
| aux_clk_buf | output | 1 | Buffered copy of `aux_clk_in` |
| aux_clk_inv | output | 1 | Inverted copy of `aux_clk_in` |
| dma_ack | input | 1 | DMA acknowledge; 1 forces the acknowledge inactive |
| ram_sel_n | input | 1 | RAM chip select, active low |
| bus_clk | output | 1 | Divided bus clock |
| xfer_ack_n | output | 1 | Transfer acknowledge to the processor, active low |
| cnt_probe | output | 1 | Wait counter bit, for observation |

## Verification
The embedded properties are checked on every fast-clock edge:
- the bus clock toggles once reset has released;
- the acknowledge moves only at bus-clock falling edges;
- a DMA acknowledge always leaves the acknowledge inactive;
- the acknowledge can only fall once the counter has been set;
- reset holds the preset values.

The full three-clock stretch, as the processor sees it at its rising-edge samples, is shown only by the bench's access scenarios. The same holds for the dependence on when the select arrives relative to the bus-clock phase, the recovery after DMA drops, and the two-edge delay on reset release.

// File: rtl/wait_ack_gen.sv
module wait_ack_gen #(
  parameter int RST_STAGES = 2
) (
  input  logic fast_clk,
  input  logic rst_n,
  input  logic aux_clk_in,
  output logic aux_clk_buf,
  output logic aux_clk_inv,
  input  logic dma_ack,
  input  logic ram_sel_n,
  output logic bus_clk,
  output logic xfer_ack_n,
  output logic cnt_probe
);

  localparam int LAST = RST_STAGES - 1;

  logic [LAST:0] rst_pipe;
  logic          run;
  logic          fall_en;
  logic          cnt_q;
  logic          ack_q;
  logic          bus_q;

  assign aux_clk_buf = aux_clk_in;
  assign aux_clk_inv = ~aux_clk_in;

  always_ff @(posedge fast_clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[LAST-1:0], 1'b1};
  end

  assign run = rst_pipe[LAST];

  always_ff @(posedge fast_clk or negedge rst_n) begin
    if (!rst_n)   bus_q <= 1'b1;
    else if (run) bus_q <= ~bus_q;
  end

  assign fall_en = run & bus_q;

  always_ff @(posedge fast_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= 1'b0;
      ack_q <= 1'b1;
    end else if (fall_en) begin
      if (dma_ack || ram_sel_n) begin
        cnt_q <= 1'b0;
        ack_q <= 1'b1;
      end else if (!cnt_q) begin
        cnt_q <= 1'b1;
      end else begin
        ack_q <= 1'b0;
      end
    end
  end

  assign bus_clk    = bus_q;
  assign xfer_ack_n = ack_q;
  assign cnt_probe  = cnt_q;

  p_toggle_r1: assert property (@(posedge fast_clk) disable iff (!rst_n)
    run |=> (bus_clk != $past(bus_clk)));

  p_reset_preset_r2: assert property (@(posedge fast_clk)
    !rst_n |-> (bus_clk && xfer_ack_n && !cnt_probe));

  p_dma_override_r3: assert property (@(posedge fast_clk) disable iff (!rst_n)
    (run && bus_clk && dma_ack) |=> xfer_ack_n);

  p_ack_on_fall_r4: assert property (@(posedge fast_clk) disable iff (!rst_n)
    !$stable(xfer_ack_n) |-> ($past(bus_clk) && !bus_clk));

  p_one_wait_r5: assert property (@(posedge fast_clk) disable iff (!rst_n)
    $fell(xfer_ack_n) |-> $past(cnt_probe));

endmodule

// File: tb/test_wait_ack_gen.sv
module test_wait_ack_gen;
  logic fast_clk = 1'b0;
  logic rst_n = 1'b1;
  logic aux_clk_in = 1'b0;
  logic dma_ack = 1'b0;
  logic ram_sel_n = 1'b1;
  logic aux_clk_buf, aux_clk_inv, bus_clk, xfer_ack_n, cnt_probe;

  int checks = 0;
  int fails = 0;
  int falls = 0;
  bit prev_bus = 1'b1;
  bit prev_ack = 1'b1;
  bit rose = 1'b0;
  bit fell = 1'b0;
  bit done = 1'b0;

  always #4 fast_clk = ~fast_clk;

  wait_ack_gen i_wait_ack_gen (
    .fast_clk(fast_clk), .rst_n(rst_n), .aux_clk_in(aux_clk_in),
    .aux_clk_buf(aux_clk_buf), .aux_clk_inv(aux_clk_inv),
    .dma_ack(dma_ack), .ram_sel_n(ram_sel_n), .bus_clk(bus_clk),
    .xfer_ack_n(xfer_ack_n), .cnt_probe(cnt_probe));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one fast cycle; model counts falling edges that see an active non-DMA select
  task automatic step();
    bit exp_ack;
    @(negedge fast_clk);
    fell = prev_bus && !bus_clk;
    rose = !prev_bus && bus_clk;
    if (fell) begin
      if (!ram_sel_n && !dma_ack) falls++;
      else falls = 0;
    end
    exp_ack = (falls >= 2) ? 1'b0 : 1'b1;
    chk(xfer_ack_n === exp_ack, dma_ack ? "R3" : (ram_sel_n ? "R6" : "R5"),
        int'(xfer_ack_n), int'(exp_ack));
    chk(cnt_probe === (falls >= 1), "R8", int'(cnt_probe), int'(falls >= 1));
    if (xfer_ack_n !== prev_ack) chk(fell, "R4", int'(fell), 1);
    prev_bus = bus_clk;
    prev_ack = xfer_ack_n;
  endtask

  task automatic wait_rise();
    do step(); while (!rose);
  endtask

  task automatic wait_fall();
    do step(); while (!fell);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ram_sel_n = 1'b1;
    dma_ack = 1'b0;
    #1;
    chk(bus_clk === 1'b1, "R2", int'(bus_clk), 1);
    chk(xfer_ack_n === 1'b1, "R2", int'(xfer_ack_n), 1);
    chk(cnt_probe === 1'b0, "R2", int'(cnt_probe), 0);
    falls = 0; prev_bus = 1'b1; prev_ack = 1'b1;
    step(); step();
    rst_n = 1'b1;
    step(); chk(bus_clk === 1'b1, "R9", int'(bus_clk), 1);
    step(); chk(bus_clk === 1'b1, "R9", int'(bus_clk), 1);
    step(); chk(bus_clk === 1'b0, "R9", int'(bus_clk), 0);
  endtask

  // phase 0: select starts just after a bus rise; phase 1: just after a fall
  task automatic access(input int phase, input int hold, input bit dma);
    bit first_ack;
    if (phase == 0) wait_rise(); else wait_fall();
    ram_sel_n = 1'b0;
    dma_ack = dma;
    first_ack = 1'b1;
    for (int k = 1; k <= hold; k++) begin
      wait_rise();
      if (phase == 0 && k == 1) first_ack = xfer_ack_n;
      if (phase == 0 && k == 2 && !dma) begin
        chk(first_ack === 1'b1, "R5", int'(first_ack), 1);
        chk(xfer_ack_n === 1'b0, "R5", int'(xfer_ack_n), 0);
      end
      if (dma) chk(xfer_ack_n === 1'b1, "R3", int'(xfer_ack_n), 1);
    end
    ram_sel_n = 1'b1;
    dma_ack = 1'b0;
    wait_fall();
    chk(xfer_ack_n === 1'b1, "R6", int'(xfer_ack_n), 1);
    step(); step();
  endtask

  initial begin
    #1 rst_n = 1'b0;
    do_reset();

    for (int c = 0; c < 20; c++) begin
      bit b0;
      b0 = bus_clk;
      step();
      chk(bus_clk !== b0, "R1", int'(bus_clk), int'(!b0));
    end

    for (int a = 0; a < 4; a++) begin
      aux_clk_in = a[0];
      #1;
      chk(aux_clk_buf === aux_clk_in, "R7", int'(aux_clk_buf), int'(aux_clk_in));
      chk(aux_clk_inv === ~aux_clk_in, "R7", int'(aux_clk_inv), int'(~aux_clk_in));
    end

    for (int ph = 0; ph < 2; ph++)
      for (int h = 1; h <= 6; h++)
        for (int d = 0; d < 2; d++)
          access(ph, h, d[0]);

    // DMA raised after acknowledge is low, then dropped with select still active
    wait_rise();
    ram_sel_n = 1'b0;
    wait_rise(); wait_rise(); wait_rise();
    chk(xfer_ack_n === 1'b0, "R5", int'(xfer_ack_n), 0);
    dma_ack = 1'b1;
    wait_fall();
    chk(xfer_ack_n === 1'b1, "R3", int'(xfer_ack_n), 1);
    dma_ack = 1'b0;
    wait_fall();
    chk(xfer_ack_n === 1'b1, "R5", int'(xfer_ack_n), 1);
    wait_fall();
    chk(xfer_ack_n === 1'b0, "R5", int'(xfer_ack_n), 0);

    // reset in the middle of an acknowledged access
    do_reset();
    access(0, 3, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule